// File: doc/BRIEF.md
# Timestamp Counter with Hardware Event Capture

This block keeps a free-running up-counter and takes hardware timestamps. The counter runs on one of two clocks: the host bus clock or an external clock pin. Software picks the clock with a control bit. A glitch-free switch moves between the two clocks, so no shortened pulse ever reaches the counter. Each capture channel has its own event input. That input is synchronized into the counter clock domain, and on a rising edge the channel stores the running count. The timestamp is therefore taken in hardware, with no software latency.

The host uses a small synchronous register port on the host clock. The port has an address, a read strobe, a write strobe and registered read data. Through it the host reads the control word, the live count, a status word and one capture register per channel. The live count crosses into the host domain as Gray code. Each capture value crosses through a request/acknowledge handshake. A read therefore never returns a word that is half old and half new. Reading a channel's capture register clears that channel's status bits.

Top module: `tsc_event_timer`

## Requirements
- R1: After reset, the control word, the status word and every capture register read as zero, and the host clock is the count source.
- R2: With the host clock selected, two live-count reads whose strobes are N host cycles apart differ by exactly N.
- R3: The counter is CNT_W bits wide (32 by default) and wraps from all ones to zero.
- R4: Control bit 0 selects the count source (0 = host clock, 1 = external pin). With the external source selected, the count advances exactly once per external rising edge and stays still while that pin is idle.
- R5: The clock switch never enables both clock sources at once, and the count steps by one on every edge of the switched clock.
- R6: The count is sampled at the first external-clock rising edge that sees the event input high. A captured value equals that sampled count plus two, because of the two synchronizer stages.
- R7: Control bit 8+i enables channel i. Events on a disabled channel change neither its status bits nor its capture register.
- R8: Status bit 2i is set when a capture of channel i reaches the host domain. It is cleared by reading channel i's capture register at byte offset 12+4i.
- R9: Status bit 2i+1 (overrun) is set when a second capture of channel i arrives before that channel is read. It is cleared by the same read.
- R10: Register map by byte address: 0 is control, 4 is the live count, 8 is status, and 12+4i is capture i. Read data and rd_valid appear one host cycle after rd_en. Writes to address 0 update the control word.
- R11: The live count reaches the host domain through a Gray-coded synchronizer, so a read returns one whole count value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock; also one of the two count sources |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| ext_clk | input | 1 | External count clock pin |
| event_in | input | NUM_CH | Event inputs, one per capture channel |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (control word only) |
| addr | input | ADDR_W | Byte address of the register |
| wr_data | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | DATA_W | Registered read data |

## Verification
The properties assume the external clock is no faster than the host clock. They also assume each event level lasts at least two count-clock edges, so the synchronizer cannot miss an edge. The stimulus drives the external clock as slow, discrete 40 ns pulses. It changes event levels only between pulses and holds each level for several edges. It leaves host cycles idle after every burst so the Gray and handshake crossings settle before a read. It also waits out the switch's enable hand-over before it counts edges in the new source.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    // Byte offsets of the register port; the capture bank starts at OFS_CAP0
    localparam int OFS_CTRL    = 0;
    localparam int OFS_LIVE    = 4;
    localparam int OFS_STAT    = 8;
    localparam int OFS_CAP0    = 12;
    localparam int CAP_STRIDE  = 4;
    // Control word fields
    localparam int CTRL_SEL_BIT = 0;
    localparam int CTRL_EN_LSB  = 8;
endpackage

// File: rtl/tsc_clk_switch.sv
module tsc_clk_switch (
    input  logic rst_n,
    input  logic clk_a,
    input  logic clk_b,
    input  logic sel_b,
    output logic clk_out,
    output logic en_a,
    output logic en_b
);
    // Each side enables only after the other side's enable has been seen low
    // on its own falling edges; enables change while their clock is low.
    logic a1_q, a2_q, b1_q, b2_q;

    always_ff @(negedge clk_a or negedge rst_n) begin
        if (!rst_n) begin
            a1_q <= 1'b1;
            a2_q <= 1'b1;
        end else begin
            a1_q <= ~sel_b & ~b2_q;
            a2_q <= a1_q;
        end
    end

    always_ff @(negedge clk_b or negedge rst_n) begin
        if (!rst_n) begin
            b1_q <= 1'b0;
            b2_q <= 1'b0;
        end else begin
            b1_q <= sel_b & ~a2_q;
            b2_q <= b1_q;
        end
    end

    assign en_a    = a2_q;
    assign en_b    = b2_q;
    assign clk_out = (clk_a & a2_q) | (clk_b & b2_q);
endmodule

// File: rtl/tsc_handshake.sv
module tsc_handshake #(
    parameter int W = 33
) (
    input  logic         rst_n,
    input  logic         src_clk,
    input  logic         src_load,
    input  logic [W-1:0] src_data,
    output logic         src_busy,
    input  logic         dst_clk,
    output logic         dst_valid,
    output logic [W-1:0] dst_data
);
    typedef struct packed {
        logic         req;
        logic [W-1:0] hold;
        logic         ack1;
        logic         ack2;
    } src_t;

    src_t s_d, s_q;
    logic r1_q, r2_q, r3_q;

    always_comb begin
        s_d      = s_q;
        s_d.ack1 = r3_q;
        s_d.ack2 = s_q.ack1;
        if (src_load) begin
            s_d.req  = ~s_q.req;
            s_d.hold = src_data;
        end
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            r1_q <= 1'b0;
            r2_q <= 1'b0;
            r3_q <= 1'b0;
        end else begin
            r1_q <= s_q.req;
            r2_q <= r1_q;
            r3_q <= r2_q;
        end
    end

    assign src_busy  = s_q.req ^ s_q.ack2;
    assign dst_valid = r2_q ^ r3_q;
    assign dst_data  = s_q.hold;   // held stable until the acknowledge returns
endmodule

// File: rtl/tsc_capture_chan.sv
module tsc_capture_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             event_in,
    input  logic [CNT_W-1:0] count,
    input  logic             busy,
    output logic             launch,
    output logic [CNT_W:0]   launch_data
);
    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             prev;
        logic [CNT_W-1:0] cap;
        logic             pending;
        logic             multi;
    } chan_t;

    chan_t c_d, c_q;
    logic rise, have_new, new_multi;
    logic [CNT_W-1:0] new_cap;

    always_comb begin
        c_d      = c_q;
        c_d.s1   = event_in;
        c_d.s2   = c_q.s1;
        c_d.prev = c_q.s2;
        rise      = c_q.s2 & ~c_q.prev & enable;
        new_cap   = rise ? count : c_q.cap;
        have_new  = c_q.pending | rise;
        new_multi = c_q.multi | (c_q.pending & rise);
        c_d.cap   = new_cap;
        launch    = have_new & ~busy;
        if (launch) begin
            c_d.pending = 1'b0;
            c_d.multi   = 1'b0;
        end else begin
            c_d.pending = have_new;
            c_d.multi   = new_multi;
        end
        launch_data = {new_multi, new_cap};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/tsc_event_timer.sv
module tsc_event_timer #(
    parameter int CNT_W  = 32,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic [NUM_CH-1:0] event_in,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    import tsc_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(OFS_LIVE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    typedef struct packed {
        logic                         sel;
        logic [NUM_CH-1:0]            en;
        logic [NUM_CH-1:0]            flag;
        logic [NUM_CH-1:0]            ovr;
        logic [NUM_CH-1:0][CNT_W-1:0] cap;
        logic [CNT_W-1:0]             g1;
        logic [CNT_W-1:0]             g2;
        logic                         rd_valid;
        logic [DATA_W-1:0]            rd_data;
    } host_t;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  gray;
        logic [NUM_CH-1:0] en1;
        logic [NUM_CH-1:0] en2;
    } cnt_t;

    function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    host_t h_d, h_q;
    cnt_t  k_d, k_q;
    logic  cnt_clk, en_a, en_b;
    logic [CNT_W-1:0] cnt_q;
    logic [NUM_CH-1:0] arrive, launch, busy, rd_hit, flag_q, ovr_q;
    logic [NUM_CH-1:0][CNT_W:0] arr_data, launch_data;
    logic [DATA_W-1:0] rd_mux;

    tsc_clk_switch u_switch (
        .rst_n (rst_n), .clk_a (clk), .clk_b (ext_clk), .sel_b (h_q.sel),
        .clk_out (cnt_clk), .en_a (en_a), .en_b (en_b)
    );

    // ---------------- count domain ----------------
    always_comb begin
        k_d      = k_q;
        k_d.cnt  = k_q.cnt + CNT_W'(1);
        k_d.gray = k_d.cnt ^ (k_d.cnt >> 1);
        k_d.en1  = h_q.en;
        k_d.en2  = k_q.en1;
    end

    always_ff @(posedge cnt_clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    assign cnt_q = k_q.cnt;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        tsc_capture_chan #(.CNT_W(CNT_W)) u_chan (
            .clk (cnt_clk), .rst_n (rst_n), .enable (k_q.en2[i]),
            .event_in (event_in[i]), .count (k_q.cnt), .busy (busy[i]),
            .launch (launch[i]), .launch_data (launch_data[i])
        );
        tsc_handshake #(.W(CNT_W + 1)) u_xfer (
            .rst_n (rst_n), .src_clk (cnt_clk), .src_load (launch[i]),
            .src_data (launch_data[i]), .src_busy (busy[i]),
            .dst_clk (clk), .dst_valid (arrive[i]), .dst_data (arr_data[i])
        );
    end

    // ---------------- host domain ----------------
    always_comb begin
        h_d          = h_q;
        h_d.g1       = k_q.gray;
        h_d.g2       = h_q.g1;
        h_d.rd_valid = rd_en;
        rd_mux       = '0;
        rd_hit       = '0;
        if (addr == A_CTRL) begin
            rd_mux[CTRL_SEL_BIT]            = h_q.sel;
            rd_mux[CTRL_EN_LSB +: NUM_CH]   = h_q.en;
        end else if (addr == A_LIVE) begin
            rd_mux = DATA_W'(gray2bin(h_q.g2));
        end else if (addr == A_STAT) begin
            for (int i = 0; i < NUM_CH; i++) begin
                rd_mux[2*i]   = h_q.flag[i];
                rd_mux[2*i+1] = h_q.ovr[i];
            end
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(OFS_CAP0 + CAP_STRIDE * i)) begin
                rd_mux    = DATA_W'(h_q.cap[i]);
                rd_hit[i] = rd_en;
            end
        end
        if (rd_en) h_d.rd_data = rd_mux;
        if (wr_en && addr == A_CTRL) begin
            h_d.sel = wr_data[CTRL_SEL_BIT];
            h_d.en  = wr_data[CTRL_EN_LSB +: NUM_CH];
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (arrive[i]) begin
                h_d.cap[i]  = arr_data[i][CNT_W-1:0];
                h_d.flag[i] = 1'b1;
                h_d.ovr[i]  = ((h_q.ovr[i] | h_q.flag[i]) & ~rd_hit[i]) | arr_data[i][CNT_W];
            end else if (rd_hit[i]) begin
                h_d.flag[i] = 1'b0;
                h_d.ovr[i]  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign flag_q   = h_q.flag;
    assign ovr_q    = h_q.ovr;
    assign rd_valid = h_q.rd_valid;
    assign rd_data  = h_q.rd_data;
endmodule

// File: rtl/tsc_event_timer_chk.sv
module tsc_event_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_clk,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              en_a,
    input logic              en_b,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_valid,
    input logic [NUM_CH-1:0] flag_q,
    input logic [NUM_CH-1:0] ovr_q,
    input logic [NUM_CH-1:0] arrive
);
    import tsc_pkg::*;
    localparam logic [ADDR_W-1:0] A_CAP0 = ADDR_W'(OFS_CAP0);

    logic armed_q;
    always_ff @(posedge cnt_clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_CLK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_a, en_b})); // R5

    AST_COUNT_STEP: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        armed_q |-> cnt_q == $past(cnt_q) + CNT_W'(1)); // R5

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R10

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R10

    AST_FLAG_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_CAP0 && !arrive[0]) |=> !flag_q[0]); // R8

    AST_FLAG_SET_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        arrive[0] |=> flag_q[0]); // R8

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive[0] && flag_q[0] && !(rd_en && addr == A_CAP0)) |=> ovr_q[0]); // R9

    AST_OVERRUN_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q & ~flag_q) == '0); // R9
endmodule

bind tsc_event_timer tsc_event_timer_chk #(
    .CNT_W (CNT_W), .NUM_CH (NUM_CH), .ADDR_W (ADDR_W)
) u_chk (
    .clk (clk), .rst_n (rst_n), .cnt_clk (cnt_clk), .cnt_q (cnt_q),
    .en_a (en_a), .en_b (en_b), .rd_en (rd_en), .addr (addr),
    .rd_valid (rd_valid), .flag_q (flag_q), .ovr_q (ovr_q), .arrive (arrive)
);

// File: tb/tb_tsc_event_timer.sv
module tb_tsc_event_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0;
    logic [1:0]  event_in = 2'b00;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid, w_rd_valid;
    logic [31:0] rd_data, w_rd_data;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q[$];
    bit          chk_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    tsc_event_timer dut (
        .clk (clk), .rst_n (rst_n), .ext_clk (ext_clk), .event_in (event_in),
        .rd_en (rd_en), .wr_en (wr_en), .addr (addr), .wr_data (wr_data),
        .rd_valid (rd_valid), .rd_data (rd_data)
    );

    tsc_event_timer #(.CNT_W(8)) dut_w (
        .clk (clk), .rst_n (rst_n), .ext_clk (ext_clk), .event_in (event_in),
        .rd_en (rd_en), .wr_en (wr_en), .addr (addr), .wr_data (wr_data),
        .rd_valid (w_rd_valid), .rd_data (w_rd_data)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Scoreboard monitor: pops one expectation per returned read
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                bit          c;
                string       t;
                e = exp_q.pop_front();
                c = chk_q.pop_front();
                t = tag_q.pop_front();
                if (c) check(t, rd_data, e);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input bit chk, input logic [31:0] exp,
                      input string tag, output logic [31:0] got, output logic [31:0] got_w);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp); chk_q.push_back(chk); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        got = rd_data; got_w = w_rd_data;
        check("R10 rd_valid one cycle after strobe", {31'd0, rd_valid}, 32'd1);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] g, gw;
        rd(a, 1'b1, exp, tag, g, gw);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; #20;
            ext_clk = 1'b0; #20;
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] a, b, v, vw, g, gw;
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 rd_valid low after reset", {31'd0, rd_valid}, 32'd0);
        expect_rd(8'd0,  32'h0, "R1 control after reset");
        expect_rd(8'd8,  32'h0, "R1 status after reset");
        expect_rd(8'd12, 32'h0, "R1 capture0 after reset");
        expect_rd(8'd16, 32'h0, "R1 capture1 after reset");

        // R2 / R11 host-clock counting: strobes 27 cycles apart
        rd(8'd4, 1'b0, 32'h0, "", a, gw);
        idle(25);
        rd(8'd4, 1'b0, 32'h0, "", b, gw);
        check("R2 host clock delta", b - a, 32'd27);
        check("R11 live read coherent", {31'd0, (b > a)}, 32'd1);

        // R4 switch to external pin, channel 0 enabled
        wr(8'd0, 32'h0000_0101);
        expect_rd(8'd0, 32'h0000_0101, "R10 control readback");
        idle(5); pulse(6); idle(8);
        rd(8'd4, 1'b0, 32'h0, "", v, gw);
        idle(10);
        expect_rd(8'd4, v, "R4 frozen while pin idle");
        pulse(7); idle(8);
        expect_rd(8'd4, v + 32'd7, "R4 counts external edges");

        // R6 / R8 single capture on channel 0
        rd(8'd4, 1'b0, 32'h0, "", v, gw);
        event_in[0] = 1'b1; pulse(10);
        event_in[0] = 1'b0; pulse(3); idle(10);
        expect_rd(8'd8,  32'h1, "R8 flag set after capture");
        expect_rd(8'd12, v + 32'd2, "R6 captured value");
        expect_rd(8'd8,  32'h0, "R8 flag cleared by read");
        expect_rd(8'd4,  v + 32'd13, "R4 count after capture burst");

        // R7 disabled channel 1 ignores its event
        event_in[1] = 1'b1; pulse(10);
        event_in[1] = 1'b0; pulse(3); idle(10);
        expect_rd(8'd8,  32'h0, "R7 disabled channel status");
        expect_rd(8'd16, 32'h0, "R7 disabled channel capture");

        // R9 overrun: two captures before the read
        rd(8'd4, 1'b0, 32'h0, "", v, gw);
        event_in[0] = 1'b1; pulse(4);
        event_in[0] = 1'b0; pulse(4);
        event_in[0] = 1'b1; pulse(10);
        event_in[0] = 1'b0; pulse(3); idle(10);
        expect_rd(8'd8,  32'h3, "R9 overrun and flag set");
        expect_rd(8'd12, v + 32'd10, "R9 latest capture kept");
        expect_rd(8'd8,  32'h0, "R9 overrun cleared by read");

        // R6 / R8 channel 1 after enabling it
        wr(8'd0, 32'h0000_0301);
        idle(3); pulse(4); idle(8);
        rd(8'd4, 1'b0, 32'h0, "", v, gw);
        event_in[1] = 1'b1; pulse(10);
        event_in[1] = 1'b0; pulse(3); idle(10);
        expect_rd(8'd8,  32'h4, "R8 channel 1 flag at bit 2");
        expect_rd(8'd16, v + 32'd2, "R6 channel 1 captured value");
        expect_rd(8'd8,  32'h0, "R8 channel 1 flag cleared");

        // R3 wrap on the 8-bit variant, none on the 32-bit one
        rd(8'd4, 1'b0, 32'h0, "", v, vw);
        pulse(261); idle(10);
        rd(8'd4, 1'b0, 32'h0, "", g, gw);
        check("R3 32-bit counter no wrap", g, v + 32'd261);
        check("R3 8-bit counter wraps", gw, (vw + 32'd5) & 32'hFF);

        // R4 / R5 switch back to the host clock
        wr(8'd0, 32'h0000_0300);
        idle(3); pulse(4); idle(10);
        rd(8'd4, 1'b0, 32'h0, "", a, gw);
        idle(25);
        rd(8'd4, 1'b0, 32'h0, "", b, gw);
        check("R5 host clock restored delta", b - a, 32'd27);

        idle(4);
        summary();
        $finish;
    end
endmodule